// File: doc/BRIEF.md
# Delayed-Write Pipelined Synchronous SRAM

This block is an on-chip synchronous SRAM whose write data trails its write command by the same number of cycles that read data trails a read command. The data bus therefore carries one transfer per cycle whatever mix of reads and writes the controller issues, with no idle turnaround slots. Each command is either a load (a new address, a read or a write, or a deselect when a chip enable is off) or a burst continuation. A burst continuation repeats the last loaded command type at the next address in a four-word wrap.

A static mode input selects between two latencies. In pipelined operation data moves two cycles after its command. In flow-through operation it moves one cycle after. A clock enable freezes the whole block for one cycle. An asynchronous output enable only gates the data-valid output. The bidirectional bus is split into `din`, `dout` and `dout_en`. A read issued while a write to the same word still waits for its data returns those pending bytes, merged lane by lane. The array is 256 words of two 9-bit lanes. A parameter selects a linear or an XOR burst order.

Top module: `ltw_sram`

## Requirements
- R1: A cycle with `cen_n`=0, `adv`=0 and all chip enables active (`ce0_n`=0, `ce1`=1, `ce2_n`=0) loads `addr`; `rw`=1 starts a read and `rw`=0 starts a write.
- R2: With `flow_thru`=0, data for a read sampled at edge k is on `dout`, with `dout_en`=1 (when `oe_n`=0), from edge k+1 to edge k+2. With `flow_thru`=1 it appears after edge k and is held until edge k+1.
- R3: Write data on `din` is sampled at edge k+2 after a write sampled at edge k when `flow_thru`=0, and at edge k+1 when `flow_thru`=1.
- R4: A word is 18 bits: lane 0 is bits 8:0 and lane 1 is bits 17:9. A write stores lane i only when `bwe_n[i]`=0, and leaves that lane unchanged when `bwe_n[i]`=1.
- R5: In pipelined mode, a read issued one cycle after a write to the same address returns that write's `din` lanes, as selected by its byte enables, merged with the stored contents of the other lanes.
- R6: Any order of reads and writes runs at one command per cycle, with no idle cycles inserted between them.
- R7: A load with any chip enable inactive is a deselect and performs no access. `dout_en` goes low only at the normal read latency, so reads already issued still complete.
- R8: With `adv`=1, the inputs `addr`, `rw` and the chip enables are ignored. The last loaded command type, including a deselect, repeats at the next burst address. The upper address bits are kept, and the low two bits advance from the load address: +1 mod 4 by default, or start XOR count when `INTERLEAVE`=1. `bwe_n` is sampled again on each burst write.
- R9: With `cen_n`=1 no state changes: the pipeline, the burst counter, the pending writes and the outputs all hold. `din` is not sampled at that edge.
- R10: `oe_n`=1 forces `dout_en` low at once, without waiting for a clock edge. It changes no state and does not affect writes.
- R11: Synchronous active-high `rst` empties the pipeline: `dout_en` is low after the reset edge, and a burst continuation issued before any load acts as a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Clock enable, active low; high stalls the block |
| adv | input | 1 | 1 = burst continuation, 0 = load |
| rw | input | 1 | On a load: 1 = read, 0 = write |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| addr | input | 8 | Word address on a load |
| bwe_n | input | 2 | Per-lane write enables, active low |
| flow_thru | input | 1 | Static: 1 = one-cycle latency, 0 = two-cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 18 | Write data, sampled at the write latency |
| dout | output | 18 | Read data |
| dout_en | output | 1 | High while `dout` carries read data and output is enabled |

## Verification
The embedded properties assume that `flow_thru` changes only while `rst` is high, because the write stage and the bypass select depend on it. The bench changes it only inside a reset window. The stall and burst-counter properties place no limit on `cen_n` or `adv`. The stimulus therefore puts stalls in the middle of a running burst and sends burst continuations straight after a deselect and straight after reset. It also offers illegal address, `rw` and chip-enable values during bursts to show that they are ignored.

// File: rtl/ltw_pkg.sv
`timescale 1ns/1ps
package ltw_pkg;
    parameter int DEPTH   = 256;
    parameter int ADDR_W  = $clog2(DEPTH);
    parameter int LANES   = 2;
    parameter int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  wmask;
    } cmd_t;

    // next low address bits of a burst: additive wrap or XOR ordering
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input bit                 xor_mode
    );
        burst_low = xor_mode ? (start ^ step) : (start + step);
    endfunction
endpackage

// File: rtl/ltw_cmd.sv
`timescale 1ns/1ps
module ltw_cmd
    import ltw_pkg::*;
#(
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              adv,
    input  logic              rw,
    input  logic              sel_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bwe_n,
    output cmd_t              nxt
);
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;
    op_e                last_q;

    assign cnt_nx = cnt_q + 1'b1;

    always_comb begin
        if (!adv) begin
            nxt.op   = sel_ok ? (rw ? OP_READ : OP_WRITE) : OP_IDLE;
            nxt.addr = addr;
        end else begin
            nxt.op   = last_q;
            nxt.addr = {base_q[ADDR_W-1:BURST_W],
                        burst_low(base_q[BURST_W-1:0], cnt_nx, INTERLEAVE)};
        end
        nxt.wmask = ~bwe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (!adv) begin
                last_q <= nxt.op;
                base_q <= addr;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_nx;
            end
        end
    end

    assert_load_kind_R1: assert property (@(posedge clk) disable iff (rst)
        (en && !adv && sel_ok) |=> (last_q == ($past(rw) ? OP_READ : OP_WRITE)));

    assert_deselect_load_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !adv && !sel_ok) |=> (last_q == OP_IDLE));

    assert_burst_step_R8: assert property (@(posedge clk) disable iff (rst)
        (en && adv) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/ltw_lane.sv
`timescale 1ns/1ps
module ltw_lane
    import ltw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              byp,
    output logic [LANE_W-1:0] q_reg,
    output logic [LANE_W-1:0] q_comb
);
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) mem[waddr] <= wdata;
    end

    assign q_comb = mem[raddr];

    // late fetch: a write landing on this same edge is forwarded
    always_ff @(posedge clk) begin
        if (rst)     q_reg <= '0;
        else if (en) q_reg <= byp ? wdata : mem[raddr];
    end

    assert_bypass_data_R5: assert property (@(posedge clk) disable iff (rst)
        (en && byp) |=> (q_reg == $past(wdata)));
endmodule

// File: rtl/ltw_sram.sv
`timescale 1ns/1ps
module ltw_sram
    import ltw_pkg::*;
#(
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              adv,
    input  logic              rw,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bwe_n,
    input  logic              flow_thru,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    logic en;
    logic sel_ok;
    cmd_t nxt;
    cmd_t s1;
    cmd_t s2;
    cmd_t ws;
    logic rd_vld_q;
    logic commit;
    logic hit;
    logic [WORD_W-1:0] q_reg_w;
    logic [WORD_W-1:0] q_comb_w;

    assign en     = !cen_n;
    assign sel_ok = !ce0_n && ce1 && !ce2_n;

    ltw_cmd #(.INTERLEAVE(INTERLEAVE)) u_cmd (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .adv    (adv),
        .rw     (rw),
        .sel_ok (sel_ok),
        .addr   (addr),
        .bwe_n  (bwe_n),
        .nxt    (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1       <= '0;
            s2       <= '0;
            rd_vld_q <= 1'b0;
        end else if (en) begin
            s1       <= nxt;
            s2       <= s1;
            rd_vld_q <= (s1.op == OP_READ);
        end
    end

    // write data arrives one stage earlier in flow-through operation
    assign ws     = flow_thru ? s1 : s2;
    assign commit = (ws.op == OP_WRITE);
    assign hit    = !flow_thru && (s2.op == OP_WRITE) && (s2.addr == s1.addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ltw_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .we     (commit && ws.wmask[g]),
            .waddr  (ws.addr),
            .wdata  (din[g*LANE_W +: LANE_W]),
            .raddr  (s1.addr),
            .byp    (hit && s2.wmask[g]),
            .q_reg  (q_reg_w[g*LANE_W +: LANE_W]),
            .q_comb (q_comb_w[g*LANE_W +: LANE_W])
        );
    end

    assign dout    = flow_thru ? q_comb_w : q_reg_w;
    assign dout_en = !oe_n && (flow_thru ? (s1.op == OP_READ) : rd_vld_q);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(s1) && $stable(s2) && $stable(rd_vld_q)));

    assert_read_stage_R2: assert property (@(posedge clk) disable iff (rst)
        (en && s1.op == OP_READ) |=> rd_vld_q);

    assert_stage_shift_R6: assert property (@(posedge clk) disable iff (rst)
        en |=> (s2 == $past(s1)));
endmodule

// File: tb/test_ltw_sram.sv
`timescale 1ns/1ps
module test_ltw_sram;
    import ltw_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              cen_n;
    logic              adv;
    logic              rw;
    logic              ce0_n;
    logic              ce1;
    logic              ce2_n;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  bwe_n;
    logic              flow_thru;
    logic              oe_n;
    logic [WORD_W-1:0] din;
    logic [WORD_W-1:0] dout;
    logic              dout_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ltw_sram i_ltw_sram (
        .clk(clk), .rst(rst), .cen_n(cen_n), .adv(adv), .rw(rw),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .addr(addr), .bwe_n(bwe_n),
        .flow_thru(flow_thru), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic        cen_n;
        logic        adv;
        logic        rw;
        logic        sel;
        logic [7:0]  addr;
        logic [1:0]  bwe_n;
        logic [17:0] din;
        logic        exp_en;
        logic [17:0] exp_d;
    } vec_t;

    localparam int NV = 28;
    // each row: inputs sampled at the next edge; expectations are outputs before that edge
    localparam vec_t VEC [NV] = '{
        {1'b0,1'b0,1'b0,1'b1,8'h10,2'b00,18'h00000,1'b0,18'h00000}, // 0  write 10 (R1)
        {1'b0,1'b0,1'b0,1'b1,8'h11,2'b00,18'h00000,1'b0,18'h00000}, // 1  write 11
        {1'b0,1'b0,1'b1,1'b1,8'h10,2'b11,18'h12345,1'b0,18'h00000}, // 2  read 10, data for row0 (R3)
        {1'b0,1'b0,1'b1,1'b1,8'h11,2'b11,18'h2ABCD,1'b0,18'h00000}, // 3  read 11
        {1'b0,1'b0,1'b0,1'b1,8'h10,2'b10,18'h00000,1'b1,18'h12345}, // 4  lane0 write 10 (R4, R6)
        {1'b0,1'b0,1'b1,1'b1,8'h10,2'b11,18'h00000,1'b1,18'h2ABCD}, // 5  read 10 pending (R5)
        {1'b0,1'b0,1'b1,1'b0,8'h10,2'b11,18'h3FFFF,1'b0,18'h00000}, // 6  deselect (R7)
        {1'b0,1'b0,1'b0,1'b0,8'h00,2'b00,18'h00000,1'b1,18'h123FF}, // 7  deselect, read completes
        {1'b0,1'b0,1'b0,1'b1,8'h20,2'b00,18'h00000,1'b0,18'h00000}, // 8  write load 20 (R8)
        {1'b0,1'b1,1'b1,1'b0,8'hFF,2'b00,18'h00000,1'b0,18'h00000}, // 9  burst -> 21, junk ignored
        {1'b0,1'b1,1'b1,1'b0,8'hFF,2'b00,18'h00001,1'b0,18'h00000}, // 10 burst -> 22
        {1'b0,1'b1,1'b0,1'b1,8'h00,2'b00,18'h00002,1'b0,18'h00000}, // 11 burst -> 23
        {1'b0,1'b0,1'b1,1'b1,8'h23,2'b11,18'h00003,1'b0,18'h00000}, // 12 read load 23
        {1'b0,1'b1,1'b0,1'b0,8'h77,2'b00,18'h00004,1'b0,18'h00000}, // 13 burst read 20 (wrap)
        {1'b0,1'b1,1'b0,1'b1,8'h00,2'b00,18'h00000,1'b1,18'h00004}, // 14 burst read 21
        {1'b0,1'b1,1'b1,1'b1,8'h00,2'b00,18'h00000,1'b1,18'h00001}, // 15 burst read 22
        {1'b1,1'b0,1'b0,1'b1,8'h50,2'b00,18'h00000,1'b1,18'h00002}, // 16 stall (R9)
        {1'b0,1'b1,1'b0,1'b0,8'h00,2'b00,18'h00000,1'b1,18'h00002}, // 17 burst read 23, held out
        {1'b0,1'b0,1'b1,1'b0,8'h00,2'b00,18'h00000,1'b1,18'h00003}, // 18 deselect
        {1'b0,1'b1,1'b1,1'b1,8'h00,2'b00,18'h00000,1'b1,18'h00004}, // 19 burst deselect
        {1'b0,1'b0,1'b0,1'b1,8'h30,2'b00,18'h00000,1'b0,18'h00000}, // 20 write 30
        {1'b0,1'b0,1'b1,1'b1,8'h30,2'b11,18'h00000,1'b0,18'h00000}, // 21 read 30 pending
        {1'b0,1'b0,1'b1,1'b1,8'h23,2'b11,18'h2AAAA,1'b0,18'h00000}, // 22 read 23
        {1'b0,1'b0,1'b0,1'b1,8'h20,2'b01,18'h00000,1'b1,18'h2AAAA}, // 23 lane1 write 20
        {1'b0,1'b0,1'b1,1'b1,8'h20,2'b11,18'h00000,1'b1,18'h00004}, // 24 read 20 pending
        {1'b0,1'b0,1'b0,1'b0,8'h00,2'b00,18'h15555,1'b0,18'h00000}, // 25 deselect
        {1'b0,1'b0,1'b0,1'b0,8'h00,2'b00,18'h00000,1'b1,18'h15401}, // 26
        {1'b0,1'b0,1'b0,1'b0,8'h00,2'b00,18'h00000,1'b0,18'h00000}  // 27
    };

    task automatic check(input string tag, input logic exp_en,
                         input logic [17:0] exp_d, input bit cmp_d);
        n_chk++;
        if (dout_en !== exp_en || (cmp_d && dout !== exp_d)) begin
            n_bad++;
            $display("FAIL %s: dout_en=%0b dout=%05h, expected dout_en=%0b dout=%05h",
                     tag, dout_en, dout, exp_en, exp_d);
        end
    endtask

    task automatic drive(input logic c, input logic a, input logic r, input logic s,
                         input logic [7:0] ad, input logic [1:0] b, input logic [17:0] d);
        cen_n = c; adv = a; rw = r;
        ce0_n = !s; ce1 = s; ce2_n = !s;
        addr = ad; bwe_n = b; din = d;
    endtask

    task automatic desel();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 2'b11, 18'h0);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; flow_thru = 1'b0; oe_n = 1'b0;
        desel();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset state", 1'b0, 18'h0, 1'b0);

        // table: pipelined mode, linear burst order (R1 R2 R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            check($sformatf("R2/R6 table row %0d", i), v.exp_en, v.exp_d, v.exp_en);
            drive(v.cen_n, v.adv, v.rw, v.sel, v.addr, v.bwe_n, v.din);
            @(negedge clk);
        end

        // R10: asynchronous output enable
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 2'b11, 18'h0);
        @(negedge clk);
        desel();
        @(negedge clk);
        check("R2 read 10 before oe test", 1'b1, 18'h123FF, 1'b1);
        oe_n = 1'b1;
        #1;
        check("R10 oe high gates output", 1'b0, 18'h0, 1'b0);
        oe_n = 1'b0;
        #1;
        check("R10 oe low restores output", 1'b1, 18'h123FF, 1'b1);

        // R11: reset empties pipeline; burst before any load is deselect
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 2'b11, 18'h0);
        @(negedge clk);
        desel();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 read dropped by reset", 1'b0, 18'h0, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h10, 2'b11, 18'h0);
        @(negedge clk);
        desel();
        @(negedge clk);
        check("R11 burst after reset is deselect", 1'b0, 18'h0, 1'b0);

        // flow-through mode, changed only during reset (R2 R3 R4)
        rst = 1'b1;
        flow_thru = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 2'b00, 18'h0);
        @(negedge clk);
        check("R11 flow idle", 1'b0, 18'h0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 2'b11, 18'h0F0F0);
        @(negedge clk);
        check("R2/R3 flow write then read", 1'b1, 18'h0F0F0, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 2'b10, 18'h0);
        @(negedge clk);
        check("R3 flow write cycle", 1'b0, 18'h0, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h40, 2'b11, 18'h000AB);
        @(negedge clk);
        check("R4 flow lane0 merge", 1'b1, 18'h0F0AB, 1'b1);
        desel();
        @(negedge clk);
        check("R7 flow deselect", 1'b0, 18'h0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule